// File: doc/BRIEF.md
# I2C Master Clock Waveform Generator

This block turns a fast peripheral clock into the SCL waveform of an I2C master. A 12-bit divisor sets the basic phase unit, and two mode bits pick the ratio of high to low time: symmetric for standard mode, or one of two asymmetric ratios for fast mode. A byte engine next to the block uses two single-cycle strobes to time its SDA changes. One strobe marks the first clock of each high phase and the other marks the first clock of each low phase.

The block has only control inputs and a waveform output. It has no data stream, so there is no valid/ready handshake. While the enable is low, SCL rests high. When the enable goes high, the waveform starts with a low phase. The divisor and the mode bits are captured once per period, at the first clock of its low phase. A change part-way through a period therefore takes effect at the next period and never shortens a phase. Each period lasts the sum of its high and low lengths, so the bit rate is the peripheral clock divided by that sum.

Top module: `scl_rate_gen`

## Requirements
- R1: With `fast_mode`=0, the high and low phases each last `divisor` clocks, whatever the value of `duty_169`.
- R2: With `fast_mode`=1 and `duty_169`=0, the high phase lasts `divisor` clocks and the low phase lasts 2×`divisor` clocks.
- R3: With `fast_mode`=1 and `duty_169`=1, the high phase lasts 9×`divisor` clocks and the low phase lasts 16×`divisor` clocks.
- R4: One period is one low phase followed by one high phase. Its length in clocks is the sum of those two lengths, and the next low phase follows with no gap.
- R5: `divisor` is 12 bits wide and takes any value up to 4095. The value 0 behaves exactly as 1.
- R6: When `enable` is 0 at a clock edge, `scl` is 1 and both strobes are 0 after that edge.
- R7: At the first edge where `enable` is 1 and the generator is idle, a low phase begins. `scl` falls and `low_start` pulses after that edge.
- R8: `divisor`, `fast_mode` and `duty_169` are sampled only at the edge that begins a low phase. Changes between those edges alter neither the running low phase nor the high phase that follows it.
- R9: `high_start` is 1 for exactly the first clock of each high phase and `low_start` for exactly the first clock of each low phase. They are never 1 together, and `scl` is 1 with `high_start` and 0 with `low_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the waveform when 1; forces idle-high when 0 |
| divisor | input | 12 | Phase unit in clocks (0 treated as 1) |
| fast_mode | input | 1 | 0: symmetric phases, 1: asymmetric fast-mode phases |
| duty_169 | input | 1 | In fast mode, selects the 9:16 ratio instead of 1:2 |
| scl | output | 1 | Generated clock line level |
| high_start | output | 1 | Pulse on the first clock of each high phase |
| low_start | output | 1 | Pulse on the first clock of each low phase |

## Verification
A phase counter that loads the wrong value or misses its terminal count shows up as a strobe one or more clocks off at the very next phase boundary. A latch that follows the live inputs instead of the period-start snapshot shows up as a wrong high length in the same period where the input changed. The bench models the expected `scl` level and both strobes on every clock. The first wrong clock is therefore reported at once, not at the end of a period. A bad idle or start condition is caught on the first clock after `enable` changes.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
  typedef enum logic [1:0] {
    RATIO_1_1  = 2'd0,
    RATIO_1_2  = 2'd1,
    RATIO_9_16 = 2'd2
  } ratio_t;

  function automatic ratio_t pick_ratio(input logic fast, input logic duty);
    if (!fast)    return RATIO_1_1;
    else if (duty) return RATIO_9_16;
    else          return RATIO_1_2;
  endfunction
endpackage

// File: rtl/scl_phase_len.sv
module scl_phase_len
  import scl_rate_pkg::*;
#(
  parameter int CW = 12,
  localparam int LW = CW + 4
) (
  input  logic [CW-1:0] ccr,
  input  logic          fast,
  input  logic          duty,
  output logic [LW-1:0] hi_len,
  output logic [LW-1:0] lo_len
);
  logic [LW-1:0] unit;
  ratio_t        ratio;

  always_comb begin
    unit  = (ccr == '0) ? LW'(1) : LW'(ccr);
    ratio = pick_ratio(fast, duty);
    unique case (ratio)
      RATIO_1_2: begin
        hi_len = unit;
        lo_len = unit << 1;
      end
      RATIO_9_16: begin
        hi_len = (unit << 3) + unit;
        lo_len = unit << 4;
      end
      default: begin
        hi_len = unit;
        lo_len = unit;
      end
    endcase
  end
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [LW-1:0] hi_in,
  input  logic [LW-1:0] lo_in,
  output logic          scl,
  output logic          hi_pulse,
  output logic          lo_pulse
);
  logic          active;
  logic          in_high;
  logic          first;
  logic [LW-1:0] remain;
  logic [LW-1:0] hold_hi;
  logic          at_end;
  logic          new_period;

  assign at_end     = (remain == '0);
  assign new_period = !active || (in_high && at_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      in_high <= 1'b0;
      first   <= 1'b0;
      remain  <= '0;
      hold_hi <= LW'(1);
    end else if (!en) begin
      active  <= 1'b0;
      in_high <= 1'b0;
      first   <= 1'b0;
      remain  <= '0;
    end else if (new_period) begin
      active  <= 1'b1;
      in_high <= 1'b0;
      first   <= 1'b1;
      remain  <= lo_in - LW'(1);
      hold_hi <= hi_in;
    end else if (!in_high && at_end) begin
      in_high <= 1'b1;
      first   <= 1'b1;
      remain  <= hold_hi - LW'(1);
    end else begin
      first   <= 1'b0;
      remain  <= remain - LW'(1);
    end
  end

  assign scl      = !active || in_high;
  assign hi_pulse = active && first && in_high;
  assign lo_pulse = active && first && !in_high;

  // R5
  hold_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (hold_hi != '0));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !lo_pulse) |-> $stable(hold_hi));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [CW-1:0] divisor,
  input  logic          fast_mode,
  input  logic          duty_169,
  output logic          scl,
  output logic          high_start,
  output logic          low_start
);
  localparam int LW = CW + 4;

  logic [LW-1:0] hi_len;
  logic [LW-1:0] lo_len;

  scl_phase_len #(.CW(CW)) u_len (
    .ccr    (divisor),
    .fast   (fast_mode),
    .duty   (duty_169),
    .hi_len (hi_len),
    .lo_len (lo_len)
  );

  scl_phase_ctr #(.LW(LW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .hi_in    (hi_len),
    .lo_in    (lo_len),
    .scl      (scl),
    .hi_pulse (high_start),
    .lo_pulse (low_start)
  );

  // R6
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl && !high_start && !low_start));

  // R7
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> (low_start && !scl));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(high_start && low_start));

  // R9
  hi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    high_start |=> !high_start);

  // R9
  lo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_start |=> !low_start);

  // R9
  strobe_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (high_start |-> scl) and (low_start |-> !scl));
endmodule

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [11:0] divisor = 12'd1;
  logic        fast_mode = 1'b0;
  logic        duty_169 = 1'b0;
  logic        scl, high_start, low_start;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // bench model state
  bit        m_active = 0;
  bit        m_high = 0;
  int        m_run = 0;
  int        m_lo = 1;
  int        m_hi = 1;
  bit        m_changed = 0;
  bit        m_zero = 0;
  bit [1:0]  m_mode = 0;

  always #10 clk = ~clk;

  scl_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .divisor(divisor),
    .fast_mode(fast_mode), .duty_169(duty_169),
    .scl(scl), .high_start(high_start), .low_start(low_start)
  );

  function automatic int unit_of(input logic [11:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  function automatic int exp_hi(input logic [11:0] d, input logic f, input logic y);
    if (f && y) return 9 * unit_of(d);
    return unit_of(d);
  endfunction

  function automatic int exp_lo(input logic [11:0] d, input logic f, input logic y);
    if (!f) return unit_of(d);
    if (y) return 16 * unit_of(d);
    return 2 * unit_of(d);
  endfunction

  function automatic string mode_tag();
    if (m_zero) return "R5";
    if (m_mode == 0) return "R1";
    if (m_mode == 1) return "R2";
    return "R3";
  endfunction

  task automatic check(input logic [2:0] exp, input string tag);
    checks++;
    if ({scl, high_start, low_start} !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: {scl,hs,ls} actual %b expected %b",
               tag, cycles, {scl, high_start, low_start}, exp);
    end
  endtask

  task automatic take_period();
    m_lo      = exp_lo(divisor, fast_mode, duty_169);
    m_hi      = exp_hi(divisor, fast_mode, duty_169);
    m_zero    = (divisor == 0);
    m_mode    = !fast_mode ? 2'd0 : (duty_169 ? 2'd2 : 2'd1);
    m_changed = 0;
  endtask

  // one clock: sample after the edge against the inputs that edge saw
  task automatic step();
    @(negedge clk);
    cycles++;
    if (!rst_n) return;
    if (!enable) begin
      m_active = 0;
      check(3'b100, "R6");
    end else if (!m_active) begin
      take_period();
      m_active = 1; m_high = 0; m_run = 1;
      check(3'b001, "R7");
    end else if (!m_high && m_run == m_lo) begin
      m_high = 1; m_run = 1;
      check(3'b110, m_changed ? "R8" : mode_tag());
    end else if (m_high && m_run == m_hi) begin
      take_period();
      m_high = 0; m_run = 1;
      check(3'b001, "R4");
    end else begin
      m_run++;
      check({m_high, 2'b00}, m_changed ? "R8" : "R9");
    end
  endtask

  task automatic set_cfg(input logic [11:0] d, input logic f, input logic y);
    if (d != divisor || f != fast_mode || y != duty_169) m_changed = 1;
    divisor = d; fast_mode = f; duty_169 = y;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #3_900_000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    run(3);
    rst_n = 1'b1;
    run(5);                                   // R6 idle after reset
    // directed: each mode, small and zero divisors
    set_cfg(12'd3, 1'b0, 1'b0); enable = 1'b1; run(40);   // R1
    set_cfg(12'd3, 1'b0, 1'b1); run(40);                  // R1 duty ignored
    set_cfg(12'd2, 1'b1, 1'b0); run(40);                  // R2
    set_cfg(12'd1, 1'b1, 1'b1); run(80);                  // R3
    set_cfg(12'd0, 1'b1, 1'b1); run(80);                  // R5 zero as one
    set_cfg(12'd0, 1'b0, 1'b0); run(20);                  // R5
    // abort mid-phase and restart (R6, R7)
    set_cfg(12'd5, 1'b1, 1'b0); run(7);
    enable = 1'b0; run(4);
    enable = 1'b1; run(30);
    // change inputs mid-period (R8)
    set_cfg(12'd4, 1'b1, 1'b1); run(70);
    set_cfg(12'd1, 1'b0, 1'b0); run(20);
    // widest divisor (R5)
    set_cfg(12'd4095, 1'b0, 1'b0); run(16400);
    set_cfg(12'd2, 1'b0, 1'b0); run(8200);
    // constrained random
    for (int k = 0; k < 20000; k++) begin
      step();
      if ($urandom_range(19) == 0) begin
        logic [11:0] d;
        d = ($urandom_range(9) == 0) ? 12'($urandom_range(40)) : 12'($urandom_range(7));
        set_cfg(d, 1'($urandom_range(1)), 1'($urandom_range(1)));
      end
      if ($urandom_range(299) == 0) enable = ~enable;
    end
    enable = 1'b0; run(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule